// File: doc/BRIEF.md
# Privileged Trap-State Register File

This block holds the supervisor and hypervisor control state of a processor core that nests traps. Each request names a bank (supervisor or hypervisor), a 5-bit index, and whether it reads or writes. It also carries two 64-bit operands. A write stores the XOR of the two operands. A read returns the selected register zero-extended to 64 bits. An access that is not allowed returns a fault code and changes no state. Every request gets a registered response exactly one cycle later.

The per-level trap records are stacks with MAX_TL entries each: saved PC, saved next PC, saved state, trap type and hypervisor saved state. The entry addressed is always TL-1, so a stack exists only while TL is nonzero. The block also holds the trap base, the processor state word, TL, the interrupt level, the window pointer and counters, window state, global level, a time counter image and the hypervisor state, pending-interrupt, base and compare registers. The block's own processor-state bit 2 (supervisor) and hypervisor-state bit 2 (hypervisor) set the current mode. That mode gates every access and selects the TL and GL clamp limits.

Top module: `trap_state_regfile`

## Requirements
- R1: After reset, TL reads MAX_TL, GL reads MAX_GL and the hypervisor state reads 0x4, with bit 2 set. Every other register reads zero, and rsp_valid is low.
- R2: A request accepted on one rising edge produces rsp_valid high after the next edge, with its data and fault. A write is visible to a read issued in the following cycle.
- R3: Write data is opnd_a XOR opnd_b. The interrupt level keeps its low PIL_W bits. The window pointer and the four window counters keep their low WIN_W bits. All other registers keep the full 64 bits.
- R4: Supervisor-bank indices are as follows. 0 is saved PC, 1 is saved next PC, 2 is saved state and 3 is trap type. 4 is tick, 5 is trap base, 6 is processor state, 7 is TL and 8 is interrupt level. 9 is the window pointer, 10 is can-save, 11 is can-restore, 12 is clean-window, 13 is other-window and 14 is window state. 16 is GL. Indices 15 and 17 to 31 give fault code 2'b01 (illegal).
- R5: Hypervisor-bank indices are as follows. 0 is hyper state, 1 is hyper saved state, 3 is hyper interrupt pending, 5 is hyper trap base, 6 is the version constant HVER_VAL and 31 is hyper compare. Every other index, and any write to index 6, gives fault 2'b01.
- R6: A trap-stack access (supervisor indices 0 to 3, hypervisor index 1) faults with 2'b01 while TL is 0. Otherwise it reaches entry TL-1, so each level keeps its own value.
- R7: The supervisor bank requires processor-state bit 2 or hyper-state bit 2. The hypervisor bank requires hyper-state bit 2. A failed mode check gives fault 2'b10 (privileged opcode), and this check takes priority over index checks.
- R8: Writing tick through the supervisor bank needs hypervisor mode, and otherwise faults 2'b10. Reading tick needs only supervisor mode.
- R9: A TL write stores min(data, MAX_PTL) when processor-state bit 2 is set and hyper-state bit 2 is clear. Otherwise it stores min(data, MAX_TL).
- R10: A GL write stores min(data, MAX_PGL) under the same supervisor-only condition as R9. Otherwise it stores min(data, MAX_GL).
- R11: A faulting access returns data zero and changes no register.
- R12: With req_valid low, the next cycle has rsp_valid low, rsp_fault zero, and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_hyp | input | 1 | Bank select: 1 = hypervisor, 0 = supervisor |
| req_idx | input | 5 | Register index within the bank |
| opnd_a | input | 64 | First source operand |
| opnd_b | input | 64 | Second source operand |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_fault | output | 2 | 00 none, 01 illegal, 10 privileged opcode |
| rsp_data | output | 64 | Read data, zero on writes and faults |

## Verification
Most wrong internal state in this block stays hidden until a later read of the same register. A bad trap-stack slot or a wrong TL only shows up after the bench moves TL and reads an earlier level back, so the directed tests do exactly that. A wrong mode bit shows up at once as an unexpected fault code in the very next response, and it then spoils every later access. For this reason the random phase keeps a full model and compares every response cycle by cycle. It also resets at regular intervals, so that a mode lost by accident does not hide later differences.

// File: rtl/trap_state_regfile.sv
module trap_state_regfile #(
  parameter int XLEN    = 64,
  parameter int MAX_TL  = 6,
  parameter int MAX_PTL = 2,
  parameter int MAX_GL  = 3,
  parameter int MAX_PGL = 2,
  parameter int WIN_W   = 3,
  parameter int PIL_W   = 4,
  parameter logic [63:0] HVER_VAL = 64'h0000_3E00_0106_0007
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic            req_hyp,
  input  logic [4:0]      req_idx,
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  output logic            rsp_valid,
  output logic [1:0]      rsp_fault,
  output logic [XLEN-1:0] rsp_data
);
  localparam int TL_W = $clog2(MAX_TL + 1);
  localparam int GL_W = $clog2(MAX_GL + 1);
  localparam logic [1:0] FLT_NONE = 2'b00;
  localparam logic [1:0] FLT_ILL  = 2'b01;
  localparam logic [1:0] FLT_PRIV = 2'b10;

  logic [XLEN-1:0] tpc_q [MAX_TL];
  logic [XLEN-1:0] tnpc_q [MAX_TL];
  logic [XLEN-1:0] tstate_q [MAX_TL];
  logic [XLEN-1:0] tt_q [MAX_TL];
  logic [XLEN-1:0] htstate_q [MAX_TL];
  logic [XLEN-1:0] tick_q, tba_q, pstate_q, wstate_q;
  logic [XLEN-1:0] hpstate_q, hintp_q, htba_q, hstick_cmpr_q;
  logic [PIL_W-1:0] pil_q;
  logic [WIN_W-1:0] cwp_q, cansave_q, canrestore_q, cleanwin_q, otherwin_q;
  logic [TL_W-1:0] tl_q;
  logic [GL_W-1:0] gl_q;

  wire in_hyp    = hpstate_q[2];
  wire in_priv   = pstate_q[2] | in_hyp;
  wire priv_only = pstate_q[2] & ~in_hyp;
  wire tl_zero   = (tl_q == '0);
  wire [TL_W-1:0] slot = tl_zero ? '0 : tl_q - 1'b1;
  wire [XLEN-1:0] wdata = opnd_a ^ opnd_b;

  wire [TL_W-1:0] tl_new = priv_only
    ? ((wdata > XLEN'(MAX_PTL)) ? TL_W'(MAX_PTL) : wdata[TL_W-1:0])
    : ((wdata > XLEN'(MAX_TL))  ? TL_W'(MAX_TL)  : wdata[TL_W-1:0]);
  wire [GL_W-1:0] gl_new = priv_only
    ? ((wdata > XLEN'(MAX_PGL)) ? GL_W'(MAX_PGL) : wdata[GL_W-1:0])
    : ((wdata > XLEN'(MAX_GL))  ? GL_W'(MAX_GL)  : wdata[GL_W-1:0]);

  logic            legal, stack;
  logic [XLEN-1:0] rd_val;
  logic [1:0]      fault;

  always_comb begin
    legal  = 1'b1;
    stack  = 1'b0;
    rd_val = '0;
    if (!req_hyp) begin
      case (req_idx)
        5'h00: begin stack = 1'b1; rd_val = tpc_q[slot]; end
        5'h01: begin stack = 1'b1; rd_val = tnpc_q[slot]; end
        5'h02: begin stack = 1'b1; rd_val = tstate_q[slot]; end
        5'h03: begin stack = 1'b1; rd_val = tt_q[slot]; end
        5'h04: rd_val = tick_q;
        5'h05: rd_val = tba_q;
        5'h06: rd_val = pstate_q;
        5'h07: rd_val = XLEN'(tl_q);
        5'h08: rd_val = XLEN'(pil_q);
        5'h09: rd_val = XLEN'(cwp_q);
        5'h0A: rd_val = XLEN'(cansave_q);
        5'h0B: rd_val = XLEN'(canrestore_q);
        5'h0C: rd_val = XLEN'(cleanwin_q);
        5'h0D: rd_val = XLEN'(otherwin_q);
        5'h0E: rd_val = wstate_q;
        5'h10: rd_val = XLEN'(gl_q);
        default: legal = 1'b0;
      endcase
    end else begin
      case (req_idx)
        5'h00: rd_val = hpstate_q;
        5'h01: begin stack = 1'b1; rd_val = htstate_q[slot]; end
        5'h03: rd_val = hintp_q;
        5'h05: rd_val = htba_q;
        5'h06: begin rd_val = HVER_VAL[XLEN-1:0]; legal = ~req_write; end
        5'h1F: rd_val = hstick_cmpr_q;
        default: legal = 1'b0;
      endcase
    end

    if (req_hyp ? !in_hyp : !in_priv)                          fault = FLT_PRIV;
    else if (!legal)                                           fault = FLT_ILL;
    else if (!req_hyp && req_idx == 5'h04 && req_write && !in_hyp) fault = FLT_PRIV;
    else if (stack && tl_zero)                                 fault = FLT_ILL;
    else                                                       fault = FLT_NONE;
  end

  wire do_write = req_valid && req_write && (fault == FLT_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_TL; i++) begin
        tpc_q[i]     <= '0;
        tnpc_q[i]    <= '0;
        tstate_q[i]  <= '0;
        tt_q[i]      <= '0;
        htstate_q[i] <= '0;
      end
      tick_q        <= '0;
      tba_q         <= '0;
      pstate_q      <= '0;
      wstate_q      <= '0;
      hpstate_q     <= XLEN'(4);
      hintp_q       <= '0;
      htba_q        <= '0;
      hstick_cmpr_q <= '0;
      pil_q         <= '0;
      cwp_q         <= '0;
      cansave_q     <= '0;
      canrestore_q  <= '0;
      cleanwin_q    <= '0;
      otherwin_q    <= '0;
      tl_q          <= TL_W'(MAX_TL);
      gl_q          <= GL_W'(MAX_GL);
    end else if (do_write) begin
      if (!req_hyp) begin
        case (req_idx)
          5'h00: tpc_q[slot]    <= wdata;
          5'h01: tnpc_q[slot]   <= wdata;
          5'h02: tstate_q[slot] <= wdata;
          5'h03: tt_q[slot]     <= wdata;
          5'h04: tick_q         <= wdata;
          5'h05: tba_q          <= wdata;
          5'h06: pstate_q       <= wdata;
          5'h07: tl_q           <= tl_new;
          5'h08: pil_q          <= wdata[PIL_W-1:0];
          5'h09: cwp_q          <= wdata[WIN_W-1:0];
          5'h0A: cansave_q      <= wdata[WIN_W-1:0];
          5'h0B: canrestore_q   <= wdata[WIN_W-1:0];
          5'h0C: cleanwin_q     <= wdata[WIN_W-1:0];
          5'h0D: otherwin_q     <= wdata[WIN_W-1:0];
          5'h0E: wstate_q       <= wdata;
          5'h10: gl_q           <= gl_new;
          default: ;
        endcase
      end else begin
        case (req_idx)
          5'h00: hpstate_q       <= wdata;
          5'h01: htstate_q[slot] <= wdata;
          5'h03: hintp_q         <= wdata;
          5'h05: htba_q          <= wdata;
          5'h1F: hstick_cmpr_q   <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= FLT_NONE;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid ? fault : FLT_NONE;
      rsp_data  <= (req_valid && !req_write && fault == FLT_NONE) ? rd_val : '0;
    end
  end
endmodule

// File: rtl/trap_state_regfile_chk.sv
module trap_state_regfile_chk #(
  parameter int XLEN   = 64,
  parameter int MAX_TL = 6,
  parameter int MAX_GL = 3,
  parameter logic [63:0] HVER_VAL = 64'h0,
  localparam int TL_W = $clog2(MAX_TL + 1),
  localparam int GL_W = $clog2(MAX_GL + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_write,
  input logic            req_hyp,
  input logic [4:0]      req_idx,
  input logic            rsp_valid,
  input logic [1:0]      rsp_fault,
  input logic [XLEN-1:0] rsp_data,
  input logic [TL_W-1:0] tl_q,
  input logic [GL_W-1:0] gl_q,
  input logic [XLEN-1:0] pstate_q,
  input logic [XLEN-1:0] hpstate_q
);
  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && rsp_fault == 2'b00 && $stable(tl_q) && $stable(gl_q)
                   && $stable(pstate_q) && $stable(hpstate_q));

  assert_fault_zero_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault != 2'b00 |-> rsp_data == '0);

  assert_tl_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tl_q <= TL_W'(MAX_TL));

  assert_gl_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    gl_q <= GL_W'(MAX_GL));

  assert_hyp_bank_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_hyp && !hpstate_q[2] |=> rsp_fault == 2'b10);

  assert_hver_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_hyp && hpstate_q[2] && !req_write && req_idx == 5'd6
    |=> rsp_fault == 2'b00 && rsp_data == HVER_VAL[XLEN-1:0]);

  assert_stack_needs_tl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_hyp && (pstate_q[2] || hpstate_q[2]) && req_idx < 5'd4 && tl_q == '0
    |=> rsp_fault == 2'b01);

  assert_tick_write_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && !req_hyp && req_idx == 5'd4 && !hpstate_q[2]
    |=> rsp_fault == 2'b10);
endmodule

bind trap_state_regfile trap_state_regfile_chk #(
  .XLEN(XLEN), .MAX_TL(MAX_TL), .MAX_GL(MAX_GL), .HVER_VAL(HVER_VAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_hyp(req_hyp), .req_idx(req_idx), .rsp_valid(rsp_valid),
  .rsp_fault(rsp_fault), .rsp_data(rsp_data), .tl_q(tl_q), .gl_q(gl_q),
  .pstate_q(pstate_q), .hpstate_q(hpstate_q)
);

// File: tb/sim_trap_state_regfile.sv
`timescale 1ns/1ps
module sim_trap_state_regfile;
  localparam logic [63:0] HV = 64'h0000_3E00_0106_0007;
  localparam int MTL = 6, MPTL = 2, MGL = 3, MPGL = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_hyp = 1'b0;
  logic [4:0] req_idx = '0;
  logic [63:0] opnd_a = '0, opnd_b = '0;
  logic rsp_valid;
  logic [1:0] rsp_fault;
  logic [63:0] rsp_data;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  trap_state_regfile #(.MAX_TL(MTL), .MAX_PTL(MPTL), .MAX_GL(MGL), .MAX_PGL(MPGL),
                       .HVER_VAL(HV)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_hyp(req_hyp), .req_idx(req_idx), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_data(rsp_data));

  logic [63:0] m_sup [32];
  logic [63:0] m_hyp [32];
  logic [63:0] m_stk [5][MTL];

  task automatic model_reset();
    for (int i = 0; i < 32; i++) begin m_sup[i] = '0; m_hyp[i] = '0; end
    for (int k = 0; k < 5; k++) for (int j = 0; j < MTL; j++) m_stk[k][j] = '0;
    m_sup[7] = 64'(MTL);
    m_sup[16] = 64'(MGL);
    m_hyp[0] = 64'd4;
  endtask

  task automatic model_step(input bit w, input bit h, input logic [4:0] idx,
                            input logic [63:0] a, input logic [63:0] b,
                            output logic [1:0] f, output logic [63:0] d);
    bit hy, pr, legal, stk;
    int kind, tl, lim;
    logic [63:0] wd;
    hy = m_hyp[0][2];
    pr = m_sup[6][2] | hy;
    wd = a ^ b;
    tl = int'(m_sup[7]);
    if (!h) begin
      legal = (idx <= 5'd14) || idx == 5'd16;
      stk = idx < 5'd4;
      kind = int'(idx);
    end else begin
      legal = (idx == 0 || idx == 1 || idx == 3 || idx == 5 || idx == 31 || (idx == 6 && !w));
      stk = idx == 5'd1;
      kind = 4;
    end
    if (h ? !hy : !pr) f = 2'b10;
    else if (!legal) f = 2'b01;
    else if (!h && idx == 5'd4 && w && !hy) f = 2'b10;
    else if (stk && tl == 0) f = 2'b01;
    else f = 2'b00;
    d = '0;
    if (f == 2'b00) begin
      if (!w) begin
        if (stk) d = m_stk[kind][tl-1];
        else if (h && idx == 5'd6) d = HV;
        else if (h) d = m_hyp[idx];
        else d = m_sup[idx];
      end else begin
        if (stk) m_stk[kind][tl-1] = wd;
        else if (h) m_hyp[idx] = wd;
        else if (idx == 5'd7) begin
          lim = (m_sup[6][2] && !hy) ? MPTL : MTL;
          m_sup[7] = (wd > 64'(lim)) ? 64'(lim) : wd;
        end else if (idx == 5'd16) begin
          lim = (m_sup[6][2] && !hy) ? MPGL : MGL;
          m_sup[16] = (wd > 64'(lim)) ? 64'(lim) : wd;
        end else if (idx == 5'd8) m_sup[8] = wd & 64'hF;
        else if (idx >= 5'd9 && idx <= 5'd13) m_sup[idx] = wd & 64'h7;
        else m_sup[idx] = wd;
      end
    end
  endtask

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic req(input string tag, input bit w, input bit h, input logic [4:0] idx,
                     input logic [63:0] a, input logic [63:0] b);
    logic [1:0] ef;
    logic [63:0] ed;
    req_valid = 1'b1; req_write = w; req_hyp = h; req_idx = idx; opnd_a = a; opnd_b = b;
    model_step(w, h, idx, a, b, ef, ed);
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, "valid", 64'(rsp_valid), 64'd1);
    chk(tag, "fault", 64'(rsp_fault), 64'(ef));
    chk(tag, "data", rsp_data, ed);
  endtask

  task automatic rd(input string tag, input bit h, input logic [4:0] idx);
    req(tag, 1'b0, h, idx, '0, '0);
  endtask
  task automatic wr(input string tag, input bit h, input logic [4:0] idx, input logic [63:0] v);
    req(tag, 1'b1, h, idx, v, 64'h0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    do_reset();
    chk("R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
    rd("R1", 0, 5'd7); rd("R1", 0, 5'd16); rd("R1", 1, 5'd0);
    rd("R1", 0, 5'd6); rd("R1", 0, 5'd5); rd("R1", 1, 5'd31);
    rd("R5", 1, 5'd6); wr("R5", 1, 5'd6, 64'h1); rd("R5", 1, 5'd2); rd("R5", 1, 5'd30);
    rd("R4", 0, 5'd15); rd("R4", 0, 5'd17); rd("R4", 0, 5'd31);
    req("R3", 1, 0, 5'd5, 64'hFFFF_0000_1234_5678, 64'h0F0F_0F0F_0F0F_0F0F);
    rd("R2", 0, 5'd5);
    wr("R3", 0, 5'd8, 64'hFF); rd("R3", 0, 5'd8);
    wr("R3", 0, 5'd9, 64'hD); rd("R3", 0, 5'd9);
    wr("R3", 0, 5'd13, 64'h1E); rd("R3", 0, 5'd13);
    wr("R6", 0, 5'd0, 64'hAAAA); wr("R6", 1, 5'd1, 64'h5151);
    wr("R6", 0, 5'd7, 64'd3);
    wr("R6", 0, 5'd0, 64'hBBBB); rd("R6", 0, 5'd0);
    wr("R6", 0, 5'd7, 64'd6); rd("R6", 0, 5'd0); rd("R6", 1, 5'd1);
    wr("R6", 0, 5'd7, 64'd0);
    rd("R6", 0, 5'd0); wr("R6", 0, 5'd3, 64'h9); rd("R6", 1, 5'd1);
    wr("R9", 0, 5'd7, 64'd9); rd("R9", 0, 5'd7);
    wr("R10", 0, 5'd16, 64'd9); rd("R10", 0, 5'd16);
    wr("R8", 0, 5'd4, 64'h77); rd("R8", 0, 5'd4);
    wr("R7", 0, 5'd6, 64'h4); wr("R7", 1, 5'd0, 64'h0);
    wr("R9", 0, 5'd7, 64'd5); rd("R9", 0, 5'd7);
    wr("R10", 0, 5'd16, 64'd7); rd("R10", 0, 5'd16);
    wr("R8", 0, 5'd4, 64'h99); rd("R11", 0, 5'd4);
    rd("R7", 1, 5'd6); wr("R11", 1, 5'd5, 64'h3); rd("R11", 0, 5'd7);
    req_valid = 1'b0; @(negedge clk);
    chk("R12", "idle rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R12", "idle rsp_fault", 64'(rsp_fault), 64'd0);
    rd("R12", 0, 5'd7);
    wr("R7", 0, 5'd6, 64'h0); rd("R7", 0, 5'd5);
    for (int c = 0; c < 40; c++) begin
      do_reset();
      for (int n = 0; n < 250; n++) begin
        bit w, h;
        logic [4:0] idx;
        logic [63:0] a, b;
        w = ($urandom % 2) == 1;
        h = ($urandom % 4) == 0;
        idx = ($urandom % 3 == 0) ? 5'($urandom % 32) : 5'($urandom % 17);
        a = {$urandom, $urandom};
        b = {$urandom, $urandom};
        if (!h && (idx == 5'd7 || idx == 5'd16)) begin a = 64'($urandom % 10); b = '0; end
        if ((!h && idx == 5'd6) || (h && idx == 5'd0))
          if ($urandom % 10 != 0) a[2] = ~b[2];
        if ($urandom % 8 == 0) begin
          req_valid = 1'b0; @(negedge clk);
          chk("R12", "idle rsp_valid", 64'(rsp_valid), 64'd0);
        end
        req(w ? "R3" : "R4", w, h, idx, a, b);
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule